// File: doc/BRIEF.md
# Active-Cluster Round-Robin Selector

This block decides which processing cluster takes part in the next transfer into the cluster array and, separately, which cluster gives up its result in the next transfer out of it. Each cluster reports two status bits. One says the cluster can accept a new vector. The other says it holds a finished result. A cluster counts as active on a side only when three conditions hold together: its status bit for that side is set, its bit in the runtime enable mask is set, and a build-time presence parameter says the cluster exists.

The two sides are independent. Each side has its own decoder, its own "last served" pointer and its own registered grant. A side that holds no grant picks the first active cluster strictly after the last one it served, wrapping from the highest index back to 0. It then presents that index together with a valid flag. The grant stays fixed until the reader (input side) or writer (output side) pulses its done strobe. That pulse moves the pointer to the served cluster and frees the side to pick again.

Top module: `clus_rr_select`

## Requirements
- R1: While reset is asserted (active low) and immediately after it, both grant-valid outputs are low. Each pointer starts at index NUM_CLUS-1, so the first grant on a side goes to the lowest-indexed active cluster.
- R2: A side with no grant held, and with at least one active cluster, raises grant-valid on the next clock edge. The grant index is the first active cluster found counting upward from last-served+1, wrapping from NUM_CLUS-1 to 0.
- R3: Cluster i is active on the input side only when `in_status[i]`, `clus_enable[i]` and `PRESENT_MASK[i]` are all 1. The output side works the same way with `out_status`. Inactive clusters are skipped.
- R4: A cluster whose `PRESENT_MASK` bit is 0 is never granted, even when its status and enable bits are 1.
- R5: While grant-valid is high and no done strobe arrives, the grant index and grant-valid stay unchanged, whatever the status and enable inputs do.
- R6: A done strobe during a held grant drops grant-valid on the next edge and makes the granted index the new last-served pointer. The pointer moves only on done, never on the grant itself.
- R7: When no cluster is active and no grant is held, grant-valid stays low and the pointer keeps its value.
- R8: The input and output sides share no state. A grant, done strobe or status change on one side has no effect on the other side's grant.
- R9: A done strobe that arrives while no grant is held is ignored and leaves the pointer unchanged.
- R10: With every present cluster continuously active, any run of as many consecutive grants as there are present clusters gives each present cluster exactly one grant.
- R11: If the only active cluster is the one served last, it is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clus_enable | input | NUM_CLUS | Runtime enable mask, one bit per cluster |
| in_status | input | NUM_CLUS | Cluster can accept a vector |
| out_status | input | NUM_CLUS | Cluster holds a result |
| in_done | input | 1 | Reader finished the granted input transfer |
| out_done | input | 1 | Writer finished the granted output transfer |
| in_gnt_valid | output | 1 | Input grant held |
| in_gnt_idx | output | IDXW | Cluster granted for input |
| out_gnt_valid | output | 1 | Output grant held |
| out_gnt_idx | output | IDXW | Cluster granted for output |

## Verification
A vector table sets the input side to a series of enable and status patterns. These patterns separate ordinary forward search from wrap-around search, from skipping through the enable mask, from skipping an absent cluster, and from re-granting the only active cluster. Directed tests then change status under a held grant to check that it holds. They leave the side with nothing active and pulse done while idle, and confirm that the next grant continues from the old pointer. They also run the output side in parallel to show the two sides are separate. A final run counts one full rotation with all clusters ready, and any cluster granted twice or never stands out.

// File: rtl/clus_rr_pkg.sv
package clus_rr_pkg;
   localparam int MAX_CLUS = 16;

   // Add a step to an index modulo n; the sum is always below 2*n.
   function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned n);
      int unsigned s;
      s = base + step;
      if (s >= n) s = s - n;
      return s;
   endfunction
endpackage

// File: rtl/clus_active_mask.sv
module clus_active_mask #(
   parameter int             NUM_CLUS     = 16,
   parameter logic [15:0]    PRESENT_MASK = 16'hFFFF
) (
   input  logic [NUM_CLUS-1:0] status,
   input  logic [NUM_CLUS-1:0] enable,
   output logic [NUM_CLUS-1:0] active
);
   for (genvar i = 0; i < NUM_CLUS; i++) begin : g_bit
      if (PRESENT_MASK[i]) begin : g_present
         assign active[i] = status[i] & enable[i];
      end else begin : g_absent
         assign active[i] = status[i] & enable[i] & 1'b0;
      end
   end
endmodule

// File: rtl/rr_next_find.sv
module rr_next_find
   import clus_rr_pkg::*;
#(
   parameter int NUM_CLUS = 16,
   parameter int IDXW     = $clog2(NUM_CLUS)
) (
   input  logic [NUM_CLUS-1:0] active,
   input  logic [IDXW-1:0]     last,
   output logic                found,
   output logic [IDXW-1:0]     pick
);
   always_comb begin
      int unsigned p;
      found = 1'b0;
      pick  = '0;
      p     = 0;
      for (int k = 1; k <= NUM_CLUS; k++) begin
         p = wrap_add(int'(last), k, NUM_CLUS);
         if (!found && active[p[IDXW-1:0]]) begin
            found = 1'b1;
            pick  = p[IDXW-1:0];
         end
      end
   end
endmodule

// File: rtl/rr_grant_side.sv
module rr_grant_side #(
   parameter int NUM_CLUS = 16,
   parameter int IDXW     = $clog2(NUM_CLUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CLUS-1:0] active,
   input  logic                done,
   output logic                gnt_valid,
   output logic [IDXW-1:0]     gnt_idx
);
   localparam logic [IDXW-1:0] LAST_INIT = IDXW'(NUM_CLUS - 1);

   logic [IDXW-1:0] last_q;
   logic            cand_found;
   logic [IDXW-1:0] cand_idx;

   rr_next_find #(.NUM_CLUS(NUM_CLUS), .IDXW(IDXW)) u_find (
      .active (active),
      .last   (last_q),
      .found  (cand_found),
      .pick   (cand_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q    <= LAST_INIT;
         gnt_valid <= 1'b0;
         gnt_idx   <= '0;
      end else if (gnt_valid) begin
         if (done) begin
            last_q    <= gnt_idx;
            gnt_valid <= 1'b0;
         end
      end else if (cand_found) begin
         gnt_valid <= 1'b1;
         gnt_idx   <= cand_idx;
      end
   end

   // Active vector of the previous cycle, used only by the checks below.
   logic [NUM_CLUS-1:0] active_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_d <= '0;
      else        active_d <= active;
   end

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !done) |=> (gnt_valid && $stable(gnt_idx)));

   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && done) |=> (!gnt_valid && last_q == $past(gnt_idx)));

   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && active == '0) |=> (!gnt_valid && $stable(last_q)));

   a_r9_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && done) |=> $stable(last_q));

   a_r2_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && active != '0) |=> gnt_valid);

   a_r3_pick_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> active_d[gnt_idx]);
endmodule

// File: rtl/clus_rr_select.sv
module clus_rr_select #(
   parameter int          NUM_CLUS     = 16,
   parameter logic [15:0] PRESENT_MASK = 16'hFFFF,
   localparam int         IDXW         = $clog2(NUM_CLUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CLUS-1:0] clus_enable,
   input  logic [NUM_CLUS-1:0] in_status,
   input  logic [NUM_CLUS-1:0] out_status,
   input  logic                in_done,
   input  logic                out_done,
   output logic                in_gnt_valid,
   output logic [IDXW-1:0]     in_gnt_idx,
   output logic                out_gnt_valid,
   output logic [IDXW-1:0]     out_gnt_idx
);
   if (NUM_CLUS < 2 || NUM_CLUS > clus_rr_pkg::MAX_CLUS) begin : g_bad_count
      $error("NUM_CLUS must lie between 2 and 16");
   end
   if (PRESENT_MASK[NUM_CLUS-1:0] == '0) begin : g_no_cluster
      $error("PRESENT_MASK enables no cluster");
   end

   logic [NUM_CLUS-1:0] in_active, out_active;

   clus_active_mask #(.NUM_CLUS(NUM_CLUS), .PRESENT_MASK(PRESENT_MASK)) u_in_mask (
      .status (in_status),  .enable (clus_enable), .active (in_active));
   clus_active_mask #(.NUM_CLUS(NUM_CLUS), .PRESENT_MASK(PRESENT_MASK)) u_out_mask (
      .status (out_status), .enable (clus_enable), .active (out_active));

   rr_grant_side #(.NUM_CLUS(NUM_CLUS), .IDXW(IDXW)) u_in_side (
      .clk (clk), .rst_n (rst_n), .active (in_active), .done (in_done),
      .gnt_valid (in_gnt_valid), .gnt_idx (in_gnt_idx));
   rr_grant_side #(.NUM_CLUS(NUM_CLUS), .IDXW(IDXW)) u_out_side (
      .clk (clk), .rst_n (rst_n), .active (out_active), .done (out_done),
      .gnt_valid (out_gnt_valid), .gnt_idx (out_gnt_idx));

   a_r4_in_present: assert property (@(posedge clk) disable iff (!rst_n)
      in_gnt_valid |-> PRESENT_MASK[in_gnt_idx]);
   a_r4_out_present: assert property (@(posedge clk) disable iff (!rst_n)
      out_gnt_valid |-> PRESENT_MASK[out_gnt_idx]);
endmodule

// File: tb/clus_rr_select_bench.sv
`timescale 1ns/1ps
module clus_rr_select_bench;
   localparam int          N    = 16;
   localparam logic [15:0] PRES = 16'hBFFF;   // cluster 14 absent

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] clus_enable = 16'hFFFF;
   logic [15:0] in_status = '0, out_status = '0;
   logic        in_done = 1'b0, out_done = 1'b0;
   logic        in_gnt_valid, out_gnt_valid;
   logic [3:0]  in_gnt_idx, out_gnt_idx;

   int n_checks = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   clus_rr_select #(.NUM_CLUS(N), .PRESENT_MASK(PRES)) u_clus_rr_select (
      .clk, .rst_n, .clus_enable, .in_status, .out_status, .in_done, .out_done,
      .in_gnt_valid, .in_gnt_idx, .out_gnt_valid, .out_gnt_idx);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [15:0] msk;
      logic [15:0] st;
      logic [3:0]  exp;
   } vec_t;

   // Walked from reset (pointer at 15).
   localparam vec_t TBL [8] = '{
      '{16'hFFFF, 16'hFFFF, 4'd0},   // R1 first grant lowest active
      '{16'hFFFF, 16'h0010, 4'd4},   // R2 forward search
      '{16'hFFFF, 16'h0011, 4'd0},   // R2 wrap to 0
      '{16'hFFFF, 16'h4001, 4'd0},   // R11 only last-served active (14 absent)
      '{16'hFFFF, 16'hC000, 4'd15},  // R4 absent 14 skipped
      '{16'h0004, 16'h0006, 4'd2},   // R3 enable mask filters 1
      '{16'hFFF7, 16'h000F, 4'd0},   // R3 masked 3 skipped, wrap
      '{16'hFFFF, 16'h8002, 4'd1}    // R2 forward to 1
   };

   task automatic in_release(input logic [15:0] next_st);
      in_done = 1'b1;
      @(negedge clk);
      in_done   = 1'b0;
      in_status = next_st;
      chk(!in_gnt_valid, "R6 valid drops after done", int'(in_gnt_valid), 0);
   endtask

   initial begin
      int hits [16];
      repeat (4) @(negedge clk);
      chk(!in_gnt_valid && !out_gnt_valid, "R1 reset grants low",
          int'({in_gnt_valid, out_gnt_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!in_gnt_valid && !out_gnt_valid, "R1 grants low after reset",
          int'({in_gnt_valid, out_gnt_valid}), 0);

      foreach (TBL[i]) begin
         clus_enable = TBL[i].msk;
         in_status   = TBL[i].st;
         @(negedge clk);
         chk(in_gnt_valid && in_gnt_idx == TBL[i].exp, "R2/R3 table grant",
             in_gnt_valid ? int'(in_gnt_idx) : -1, int'(TBL[i].exp));
         in_release(TBL[i].st);
      end
      clus_enable = 16'hFFFF;

      // R5 hold under changing status; R8 output side alongside
      in_status = 16'hFFFF;
      @(negedge clk);
      chk(in_gnt_valid && in_gnt_idx == 4'd2, "R2 grant after 1", int'(in_gnt_idx), 2);
      in_status  = 16'h0001;
      out_status = 16'h0300;
      @(negedge clk);
      chk(out_gnt_valid && out_gnt_idx == 4'd8, "R8 output first grant", int'(out_gnt_idx), 8);
      out_done = 1'b1;
      @(negedge clk);
      out_done = 1'b0;
      chk(!out_gnt_valid, "R6 output valid drops", int'(out_gnt_valid), 0);
      @(negedge clk);
      chk(out_gnt_valid && out_gnt_idx == 4'd9, "R8 output next grant", int'(out_gnt_idx), 9);
      clus_enable = 16'h0001;
      @(negedge clk);
      chk(in_gnt_valid && in_gnt_idx == 4'd2, "R5 input grant held", int'(in_gnt_idx), 2);
      chk(out_gnt_valid && out_gnt_idx == 4'd9, "R5 output grant held", int'(out_gnt_idx), 9);
      clus_enable = 16'hFFFF;
      in_release(16'h0000);                          // last = 2

      // R7 nothing active
      repeat (3) @(negedge clk);
      chk(!in_gnt_valid, "R7 no grant when idle", int'(in_gnt_valid), 0);
      // R9 stray done
      in_done = 1'b1;
      @(negedge clk);
      in_done = 1'b0;
      @(negedge clk);
      in_status = 16'hFFFF;
      @(negedge clk);
      chk(in_gnt_valid && in_gnt_idx == 4'd3, "R9 pointer kept after stray done",
          int'(in_gnt_idx), 3);
      chk(out_gnt_valid && out_gnt_idx == 4'd9, "R8 output untouched", int'(out_gnt_idx), 9);

      // R10 full rotation
      foreach (hits[i]) hits[i] = 0;
      for (int g = 0; g < 15; g++) begin
         if (in_gnt_valid) hits[in_gnt_idx]++;
         in_release(16'hFFFF);
         @(negedge clk);
      end
      for (int c = 0; c < N; c++)
         chk(hits[c] == (PRES[c] ? 1 : 0), "R10 one grant per cluster", hits[c],
             PRES[c] ? 1 : 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule